// File: doc/BRIEF.md
# Partition-Monitoring Control Register Bank

This block is the storage and read-view logic for a processor core's memory-partitioning controls. It holds a read-only capability register, one control word per privilege level (0 to 3), a hypervisor control word, a virtual-map valid word, a set of virtual-partition map words and a streaming-mode word. Software reaches each of them through a 16-bit system-register coordinate. The bank decodes that coordinate combinationally on one read port and one write port.

Writes are filtered so that reserved bit positions always store zero. Reads of the level-1 and level-2 control words are assembled from more than one register. The global enable bit comes from the highest implemented level. On level-1 reads a security-forcing bit is taken from the level-3 word. When level 2 runs in host mode, level-1 accesses made at level 2 land on the level-2 word. A dedicated alias coordinate always reaches the level-1 word. Permission checking and trap routing are done elsewhere. This bank assumes every access presented to it is legal.

Top module: `part_ctl_regbank`

## Requirements
- R1: A coordinate is packed as {op0[15:14], op1[13:11], crn[10:7], crm[6:3], op2[2:0]}. Every decoded coordinate has op0=3 and crn=10. The decoded coordinates, as (op1,crm,op2), are: capability (0,4,4); level-1 (0,5,0); level-0 (0,5,1); streaming (0,5,3); hypervisor control (4,4,0); map-valid (4,4,1); level-2 (4,5,0); map word n (4,6,n) for n below NUM_VMAP; level-1 alias (5,5,0); level-3 (6,5,0). Any other coordinate reads with rd_hit=0 and rd_data=0.
- R2: After reset, every register except the capability register reads as zero.
- R3: The capability register always reads 0x34000040001E0100.
- R4: A write stores wr_data with these reserved bits forced to zero: level-0 [63:48]; level-1 [62:61],[59:48]; level-2 [62:59],[57:50]; level-3 [59:48]; hypervisor control all but bits 31, 8, 1, 0; map-valid [63:32]; streaming [63:48],[39:32],[15:0]; map words none.
- R5: Writes to the capability coordinate or to an undecoded coordinate change no register.
- R6: Reads of the level-1 word (direct or alias) and of the level-2 word return bit 63 equal to bit 63 of the level-HIGHEST_LVL word.
- R7: On a level-1 read, bit 60 equals level-3 bit 60 when secure_state=1, and 0 otherwise.
- R8: With cur_lvl=2 and host_mode=1, the level-1 coordinate reads and writes the level-2 word, with level-2 masking and composition.
- R9: The alias coordinate always reaches the level-1 word, whatever the mode. Writes through it clear only bits [59:48].
- R10: Reads are combinational in the same cycle. A write becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level of the accessing core |
| host_mode | input | 1 | Level 2 is running in host mode |
| secure_state | input | 1 | Core is in secure state |
| rd_coord | input | 16 | Read coordinate |
| rd_hit | output | 1 | Read coordinate decodes to a register |
| rd_data | output | 64 | Composed read value |
| wr_en | input | 1 | Write strobe |
| wr_coord | input | 16 | Write coordinate |
| wr_data | input | 64 | Write value before masking |

## Verification
A corrupted stored word shows up on the very next combinational read of its coordinate. A corrupted level-3 word is also visible through bits 63 and 60 of the level-1 reads and through bit 63 of the level-2 reads. A decode or redirect error makes a write land in the wrong word. The bench catches this because, after every write, it reads back every decoded coordinate. A stray change therefore surfaces within one cycle of the write that caused it. A reserved bit that leaks into storage appears as a nonzero bit in the next read of that word.

// File: rtl/partreg_pkg.sv
package partreg_pkg;

  typedef enum logic [3:0] {
    T_NONE, T_ID, T_L0, T_L1, T_L1ALIAS, T_L2, T_L3,
    T_HCTL, T_VVALID, T_VMAP, T_STREAM
  } tgt_kind_e;

  localparam logic [63:0] CAP_VALUE = 64'h3400_0040_001E_0100;

  function automatic logic [63:0] bit_rng(input int hi, input int lo);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [63:0] KEEP_L0     = ~bit_rng(63, 48);
  localparam logic [63:0] KEEP_L1     = ~(bit_rng(62, 61) | bit_rng(59, 48));
  localparam logic [63:0] KEEP_ALIAS  = ~bit_rng(59, 48);
  localparam logic [63:0] KEEP_L2     = ~(bit_rng(62, 59) | bit_rng(57, 50));
  localparam logic [63:0] KEEP_L3     = ~bit_rng(59, 48);
  localparam logic [63:0] KEEP_HCTL   = bit_rng(31, 31) | bit_rng(8, 8) | bit_rng(1, 0);
  localparam logic [63:0] KEEP_VVALID = bit_rng(31, 0);
  localparam logic [63:0] KEEP_STREAM = bit_rng(47, 40) | bit_rng(31, 16);

endpackage

// File: rtl/part_rst_sync.sv
module part_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/part_coord_decode.sv
module part_coord_decode
  import partreg_pkg::*;
#(
  parameter int NUM_VMAP = 8,
  localparam int VSEL_W = (NUM_VMAP > 1) ? $clog2(NUM_VMAP) : 1
) (
  input  logic [15:0]       coord,
  input  logic [1:0]        cur_lvl,
  input  logic              host_mode,
  output tgt_kind_e         kind,
  output logic [VSEL_W-1:0] vsel
);
  logic [1:0] op0;
  logic [2:0] op1;
  logic [3:0] crn;
  logic [3:0] crm;
  logic [2:0] op2;
  tgt_kind_e  raw_kind;

  assign {op0, op1, crn, crm, op2} = coord;

  always_comb begin
    raw_kind = T_NONE;
    vsel     = op2[VSEL_W-1:0];
    if (op0 == 2'd3 && crn == 4'd10) begin
      unique case (op1)
        3'd0: begin
          if      (crm == 4'd4 && op2 == 3'd4) raw_kind = T_ID;
          else if (crm == 4'd5 && op2 == 3'd0) raw_kind = T_L1;
          else if (crm == 4'd5 && op2 == 3'd1) raw_kind = T_L0;
          else if (crm == 4'd5 && op2 == 3'd3) raw_kind = T_STREAM;
        end
        3'd4: begin
          if      (crm == 4'd4 && op2 == 3'd0) raw_kind = T_HCTL;
          else if (crm == 4'd4 && op2 == 3'd1) raw_kind = T_VVALID;
          else if (crm == 4'd5 && op2 == 3'd0) raw_kind = T_L2;
          else if (crm == 4'd6 && int'(op2) < NUM_VMAP) raw_kind = T_VMAP;
        end
        3'd5: if (crm == 4'd5 && op2 == 3'd0) raw_kind = T_L1ALIAS;
        3'd6: if (crm == 4'd5 && op2 == 3'd0) raw_kind = T_L3;
        default: raw_kind = T_NONE;
      endcase
    end
  end

  // host-mode redirect of level-1 accesses made at level 2
  always_comb begin
    kind = raw_kind;
    if (raw_kind == T_L1 && cur_lvl == 2'd2 && host_mode) kind = T_L2;
  end
endmodule

// File: rtl/part_wr_mask.sv
module part_wr_mask
  import partreg_pkg::*;
(
  input  tgt_kind_e   kind,
  input  logic [63:0] wdata,
  output logic [63:0] wdata_m
);
  logic [63:0] keep;
  always_comb begin
    unique case (kind)
      T_L0:      keep = KEEP_L0;
      T_L1:      keep = KEEP_L1;
      T_L1ALIAS: keep = KEEP_ALIAS;
      T_L2:      keep = KEEP_L2;
      T_L3:      keep = KEEP_L3;
      T_HCTL:    keep = KEEP_HCTL;
      T_VVALID:  keep = KEEP_VVALID;
      T_VMAP:    keep = '1;
      T_STREAM:  keep = KEEP_STREAM;
      default:   keep = '0;
    endcase
    wdata_m = wdata & keep;
  end
endmodule

// File: rtl/part_rd_compose.sv
module part_rd_compose
  import partreg_pkg::*;
(
  input  tgt_kind_e   kind,
  input  logic [63:0] raw,
  input  logic        hi_en,
  input  logic        l3_force,
  input  logic        secure_state,
  output logic        hit,
  output logic [63:0] data
);
  always_comb begin
    hit  = 1'b1;
    data = raw;
    unique case (kind)
      T_NONE: begin
        hit  = 1'b0;
        data = '0;
      end
      T_ID: data = CAP_VALUE;
      T_L1, T_L1ALIAS: begin
        data[63] = hi_en;
        data[60] = secure_state & l3_force;
      end
      T_L2: data[63] = hi_en;
      default: data = raw;
    endcase
  end
endmodule

// File: rtl/part_ctl_regbank.sv
module part_ctl_regbank
  import partreg_pkg::*;
#(
  parameter int NUM_VMAP    = 8,
  parameter int HIGHEST_LVL = 3,
  localparam int VSEL_W = (NUM_VMAP > 1) ? $clog2(NUM_VMAP) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cur_lvl,
  input  logic        host_mode,
  input  logic        secure_state,
  input  logic [15:0] rd_coord,
  output logic        rd_hit,
  output logic [63:0] rd_data,
  input  logic        wr_en,
  input  logic [15:0] wr_coord,
  input  logic [63:0] wr_data
);
  logic              rst_sync_n;
  tgt_kind_e         rd_kind, wr_kind;
  logic [VSEL_W-1:0] rd_vsel, wr_vsel;
  logic [63:0]       wdata_m;
  logic [63:0]       raw_rd;
  logic              hi_en;

  logic [63:0] l0_q, l1_q, l2_q, l3_q, hctl_q, vvalid_q, stream_q;
  logic [63:0] l0_d, l1_d, l2_d, l3_d, hctl_d, vvalid_d, stream_d;
  logic        we_l0, we_l1, we_l2, we_l3, we_hctl, we_vvalid, we_stream;
  logic [63:0] vmap_q [NUM_VMAP];

  part_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  part_coord_decode #(.NUM_VMAP(NUM_VMAP)) u_rd_dec (
    .coord(rd_coord), .cur_lvl(cur_lvl), .host_mode(host_mode),
    .kind(rd_kind), .vsel(rd_vsel)
  );

  part_coord_decode #(.NUM_VMAP(NUM_VMAP)) u_wr_dec (
    .coord(wr_coord), .cur_lvl(cur_lvl), .host_mode(host_mode),
    .kind(wr_kind), .vsel(wr_vsel)
  );

  part_wr_mask u_mask (.kind(wr_kind), .wdata(wr_data), .wdata_m(wdata_m));

  // write enables
  always_comb begin
    we_l0     = wr_en && wr_kind == T_L0;
    we_l1     = wr_en && (wr_kind == T_L1 || wr_kind == T_L1ALIAS);
    we_l2     = wr_en && wr_kind == T_L2;
    we_l3     = wr_en && wr_kind == T_L3;
    we_hctl   = wr_en && wr_kind == T_HCTL;
    we_vvalid = wr_en && wr_kind == T_VVALID;
    we_stream = wr_en && wr_kind == T_STREAM;
  end

  // next state
  always_comb begin
    l0_d     = we_l0     ? wdata_m : l0_q;
    l1_d     = we_l1     ? wdata_m : l1_q;
    l2_d     = we_l2     ? wdata_m : l2_q;
    l3_d     = we_l3     ? wdata_m : l3_q;
    hctl_d   = we_hctl   ? wdata_m : hctl_q;
    vvalid_d = we_vvalid ? wdata_m : vvalid_q;
    stream_d = we_stream ? wdata_m : stream_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      l0_q     <= '0;
      l1_q     <= '0;
      l2_q     <= '0;
      l3_q     <= '0;
      hctl_q   <= '0;
      vvalid_q <= '0;
      stream_q <= '0;
    end else begin
      l0_q     <= l0_d;
      l1_q     <= l1_d;
      l2_q     <= l2_d;
      l3_q     <= l3_d;
      hctl_q   <= hctl_d;
      vvalid_q <= vvalid_d;
      stream_q <= stream_d;
    end
  end

  for (genvar g = 0; g < NUM_VMAP; g++) begin : g_vmap
    logic        we_v;
    logic [63:0] v_d;
    always_comb begin
      we_v = wr_en && wr_kind == T_VMAP && int'(wr_vsel) == g;
      v_d  = we_v ? wdata_m : vmap_q[g];
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) vmap_q[g] <= '0;
      else             vmap_q[g] <= v_d;
    end
  end

  // enable source: highest implemented level
  if (HIGHEST_LVL >= 3) begin : g_hi3
    assign hi_en = l3_q[63];
  end else if (HIGHEST_LVL == 2) begin : g_hi2
    assign hi_en = l2_q[63];
  end else begin : g_hi1
    assign hi_en = l1_q[63];
  end

  // raw read mux
  always_comb begin
    unique case (rd_kind)
      T_L0:            raw_rd = l0_q;
      T_L1, T_L1ALIAS: raw_rd = l1_q;
      T_L2:            raw_rd = l2_q;
      T_L3:            raw_rd = l3_q;
      T_HCTL:          raw_rd = hctl_q;
      T_VVALID:        raw_rd = vvalid_q;
      T_VMAP:          raw_rd = vmap_q[rd_vsel];
      T_STREAM:        raw_rd = stream_q;
      default:         raw_rd = '0;
    endcase
  end

  part_rd_compose u_compose (
    .kind(rd_kind), .raw(raw_rd), .hi_en(hi_en), .l3_force(l3_q[60]),
    .secure_state(secure_state), .hit(rd_hit), .data(rd_data)
  );

  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_kind == T_NONE) |-> (!rd_hit && rd_data == 64'd0));

  // R5
  no_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (wr_kind == T_NONE || wr_kind == T_ID)) |=>
      ($stable(l0_q) && $stable(l1_q) && $stable(l2_q) && $stable(l3_q) &&
       $stable(hctl_q) && $stable(vvalid_q) && $stable(stream_q)));

  // R4
  stream_rsv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stream_q[15:0] == 16'd0 && stream_q[39:32] == 8'd0 && stream_q[63:48] == 16'd0));

  // R6
  enable_view_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_kind == T_L1 || rd_kind == T_L1ALIAS || rd_kind == T_L2) |-> (rd_data[63] == hi_en));

  // R7
  nonsec_force_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rd_kind == T_L1 || rd_kind == T_L1ALIAS) && !secure_state) |-> (rd_data[60] == 1'b0));

  // R8
  host_redirect_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_coord == 16'hC528 && cur_lvl == 2'd2 && host_mode) |-> (rd_kind == T_L2));

  // R10
  l3_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && wr_kind == T_L3) |=> $stable(l3_q));
endmodule

// File: tb/tb_part_ctl_regbank.sv
module tb_part_ctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cur_lvl;
  logic        host_mode, secure_state;
  logic [15:0] rd_coord, wr_coord;
  logic        rd_hit, wr_en;
  logic [63:0] rd_data, wr_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] bm [0:14];
  logic [15:0] known [0:16];

  always #4 clk = ~clk;

  part_ctl_regbank dut (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .host_mode(host_mode),
    .secure_state(secure_state), .rd_coord(rd_coord), .rd_hit(rd_hit),
    .rd_data(rd_data), .wr_en(wr_en), .wr_coord(wr_coord), .wr_data(wr_data)
  );

  function automatic logic [63:0] rng(int hi, int lo);
    logic [63:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] mk(int o1, int cm, int o2);
    return {2'd3, 3'(o1), 4'd10, 4'(cm), 3'(o2)};
  endfunction

  // -1 none, 0..14 storage, 15 capability, 16 alias
  function automatic int tgt_of(logic [15:0] c);
    int o1, cm, o2;
    if (c[15:14] != 2'd3 || c[10:7] != 4'd10) return -1;
    o1 = int'(c[13:11]); cm = int'(c[6:3]); o2 = int'(c[2:0]);
    if (o1 == 0 && cm == 4 && o2 == 4) return 15;
    if (o1 == 0 && cm == 5 && o2 == 0) return (cur_lvl == 2 && host_mode) ? 2 : 1;
    if (o1 == 0 && cm == 5 && o2 == 1) return 0;
    if (o1 == 0 && cm == 5 && o2 == 3) return 14;
    if (o1 == 4 && cm == 4 && o2 == 0) return 4;
    if (o1 == 4 && cm == 4 && o2 == 1) return 5;
    if (o1 == 4 && cm == 5 && o2 == 0) return 2;
    if (o1 == 4 && cm == 6)            return 6 + o2;
    if (o1 == 5 && cm == 5 && o2 == 0) return 16;
    if (o1 == 6 && cm == 5 && o2 == 0) return 3;
    return -1;
  endfunction

  function automatic logic [63:0] keep_of(int t);
    case (t)
      0:  return rng(47, 0);
      1:  return ~(rng(62, 61) | rng(59, 48));
      16: return ~rng(59, 48);
      2:  return ~(rng(62, 59) | rng(57, 50));
      3:  return ~rng(59, 48);
      4:  return rng(31, 31) | rng(8, 8) | rng(1, 0);
      5:  return rng(31, 0);
      14: return rng(47, 40) | rng(31, 16);
      default: return (t >= 6 && t <= 13) ? '1 : '0;
    endcase
  endfunction

  function automatic logic [63:0] exp_rd(int t);
    logic [63:0] v;
    if (t < 0)   return '0;
    if (t == 15) return 64'h3400_0040_001E_0100;
    if (t == 1 || t == 16) begin
      v = bm[1]; v[63] = bm[3][63]; v[60] = secure_state ? bm[3][60] : 1'b0;
      return v;
    end
    if (t == 2) begin v = bm[2]; v[63] = bm[3][63]; return v; end
    return bm[t];
  endfunction

  function automatic string req_of(int t, logic [15:0] c);
    if (t < 0)   return "R1";
    if (t == 15) return "R3";
    if (t == 16) return "R9";
    if (t == 2 && c == mk(0, 5, 0)) return "R8";
    if (t == 1 || t == 2) return "R6/R7";
    return "R4";
  endfunction

  task automatic check_read(logic [15:0] c, string req);
    int t = tgt_of(c);
    logic [63:0] e = exp_rd(t);
    rd_coord = c;
    #1;
    checks++;
    if (rd_data !== e || rd_hit !== (t >= 0)) begin
      errors++;
      $display("FAIL %s coord=%h got=%h hit=%b exp=%h hit=%b", req, c, rd_data, rd_hit, e, t >= 0);
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 17; k++) check_read(known[k], req);
  endtask

  task automatic do_write(logic [15:0] c, logic [63:0] d);
    int t;
    @(negedge clk);
    t = tgt_of(c);
    wr_coord = c; wr_data = d; wr_en = 1'b1;
    check_read(c, "R10");
    @(negedge clk);
    wr_en = 1'b0;
    if (t >= 0 && t != 15) bm[(t == 16) ? 1 : t] = d & keep_of(t);
    check_read(c, (t < 0 || t == 15) ? "R5" : req_of(t, c));
    check_all((t < 0 || t == 15) ? "R5" : "R4");
  endtask

  task automatic sweep(logic [1:0] lvl, logic host, logic sec, logic [63:0] pat);
    int ops [5] = '{0, 4, 5, 6, 1};
    cur_lvl = lvl; host_mode = host; secure_state = sec;
    foreach (ops[i]) begin
      for (int cm = 0; cm < 16; cm++) begin
        for (int o2 = 0; o2 < 8; o2++) begin
          if (ops[i] == 1 || cm >= 4 && cm <= 6)
            do_write(mk(ops[i], cm, o2), pat ^ {32'(cm), 32'(o2 * 3)});
          else
            check_read(mk(ops[i], cm, o2), "R1");
        end
      end
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) bm[i] = '0;
    known[0] = mk(0, 4, 4); known[1] = mk(0, 5, 0); known[2] = mk(0, 5, 1);
    known[3] = mk(0, 5, 3); known[4] = mk(4, 4, 0); known[5] = mk(4, 4, 1);
    known[6] = mk(4, 5, 0); known[7] = mk(5, 5, 0); known[8] = mk(6, 5, 0);
    for (int i = 0; i < 8; i++) known[9 + i] = mk(4, 6, i);
    rst_n = 1'b0; wr_en = 1'b0; wr_coord = '0; wr_data = '0; rd_coord = '0;
    cur_lvl = 2'd1; host_mode = 1'b0; secure_state = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R2");
    check_read(known[0], "R3");
    check_read({2'd2, 3'd0, 4'd10, 4'd5, 3'd0}, "R1");
    check_read({2'd3, 3'd0, 4'd9, 4'd5, 3'd0}, "R1");
    sweep(2'd1, 1'b0, 1'b0, '1);
    sweep(2'd2, 1'b1, 1'b1, 64'hA5A5_5A5A_C3C3_3C3C);
    sweep(2'd3, 1'b0, 1'b1, '1);
    sweep(2'd2, 1'b0, 1'b0, 64'h5A5A_A5A5_0F0F_F0F0);
    sweep(2'd2, 1'b1, 1'b0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule